// File: doc/BRIEF.md
# Phase History Table Degree Predictor

This block picks the pipeline depth degree for each coming execution interval. At the end of every interval it receives that interval's finished code-footprint signature, together with the power/performance metric measured while the interval ran. It searches a small history table for the stored signature closest to the new one. It then either reuses what it learned about the interval that followed the earlier occurrence, or starts a fresh table entry. It returns one of three degrees (full depth U1, half depth U2, quarter depth U4) and asks for the signature vector to be cleared.

Each table entry is keyed by one interval's signature but holds tuning results for the interval that comes after it. A newly allocated entry is tried at U1, U2 and U4 on its next three recurrences. Once all three metrics are in, the lowest one fixes the entry's best degree. A register remembers the entry chosen last time, and the next measured metric is written into that entry. When the table is full, entries still being tuned are replaced before tuned ones, and the least recently touched entry goes first within each class.

The signature input is a valid/ready stream. A transfer happens only on a clock edge where `sig_valid` and `sig_ready` are both high. `sig_ready` falls for the whole search, and a value offered while it is low is not taken. The upstream side must hold `sig`, `metric_in` and `sig_valid` until the transfer. The result leaves as a one-cycle pulse with no back-pressure.

Top module: `phase_degree_predictor`

## Requirements
- R1: A signature is accepted only on an edge with `sig_valid` and `sig_ready` both high. `sig_ready` is low from the cycle after acceptance until the cycle in which `degree_valid` is high. Anything offered while `sig_ready` is low is ignored and produces no result.
- R2: Each accepted signature produces exactly one single-cycle `degree_valid` pulse, with `sig_clear` high in the same cycle, no more than 50 cycles after acceptance. `degree` encodes 2'b00 = U1, 2'b01 = U2, 2'b10 = U4 and never 2'b11.
- R3: The distance between two signatures is the count of ones in their XOR divided by the count of ones in their OR, taken as 0 when both are all-zero. The lookup picks the valid entry with the smallest distance, with ties going to the lowest index. It is a hit when that distance is at most one half, and a miss when it is above one half or the table is empty.
- R4: On a miss, a new entry is written with the incoming signature in the tuning state with no metrics tried, and the output degree is U1.
- R5: On a hit to a tuning entry, the output degree is the next untried one in the order U1, U2, U4.
- R6: The metric arriving with a signature is written into the entry selected for the previous interval, in the slot of the degree that interval ran at. When that entry is tuning and the slot is U4, the entry becomes tuned and its best degree is the one with the lowest 16-bit unsigned metric, ties going to U1, then U2, then U4.
- R7: On a hit to a tuned entry, the output degree is that entry's best degree. A metric written into an already tuned entry replaces that slot, and the best degree is recomputed.
- R8: Allocation uses an empty entry if any. Otherwise it evicts the least recently touched tuning entry, and only if there is none the least recently touched tuned entry. An entry counts as touched when it is hit or allocated.
- R9: After reset the table is empty, no previous entry is selected, the last-used degree is U1, `sig_ready` is high, and `degree_valid` and `sig_clear` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sig_valid | input | 1 | Signature and metric offered |
| sig_ready | output | 1 | Block idle and able to take a signature |
| sig | input | 128 | Finished interval's signature vector |
| metric_in | input | 16 | Metric of the finished interval, lower is better |
| degree_valid | output | 1 | One-cycle pulse marking a new degree |
| degree | output | 2 | Degree for the next interval (00 U1, 01 U2, 10 U4) |
| sig_clear | output | 1 | One-cycle request to clear the signature vector |

## Verification
A corrupted entry field usually stays hidden until its phase recurs. A lost tuning step shows as a repeated or skipped degree on the next hit to that entry. A best degree that is not recomputed shows only when a tuned entry is hit after a metric that should have moved its minimum. A wrong eviction shows several intervals later, as a U1 miss where a hit was due, or as a hit where a miss was due. The stimulus is therefore arranged so that each of these faults changes a specific later degree. The per-request checks cover the handshake, the pulse and the latency bound immediately.

// File: rtl/phd_pkg.sv
package phd_pkg;

  typedef enum logic [1:0] {
    DEG_U1 = 2'b00,
    DEG_U2 = 2'b01,
    DEG_U4 = 2'b10
  } deg_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_UPDATE,
    ST_SEARCH,
    ST_DECIDE
  } fsm_e;

endpackage

// File: rtl/phd_distance.sv
module phd_distance #(
  parameter int SIG_W = 128,
  parameter int CNT_W = 8
) (
  input  logic [SIG_W-1:0] sig_a,
  input  logic [SIG_W-1:0] sig_b,
  output logic [CNT_W-1:0] diff_cnt,
  output logic [CNT_W-1:0] union_cnt
);
  always_comb begin
    diff_cnt  = '0;
    union_cnt = '0;
    for (int i = 0; i < SIG_W; i++) begin
      diff_cnt  = diff_cnt  + CNT_W'(sig_a[i] ^ sig_b[i]);
      union_cnt = union_cnt + CNT_W'(sig_a[i] | sig_b[i]);
    end
  end
endmodule

// File: rtl/phd_best_sel.sv
module phd_best_sel
  import phd_pkg::*;
#(
  parameter int MET_W = 16
) (
  input  logic [MET_W-1:0] m_u1,
  input  logic [MET_W-1:0] m_u2,
  input  logic [MET_W-1:0] m_u4,
  output deg_e             best
);
  always_comb begin
    if (m_u1 <= m_u2 && m_u1 <= m_u4) best = DEG_U1;
    else if (m_u2 <= m_u4)            best = DEG_U2;
    else                              best = DEG_U4;
  end
endmodule

// File: rtl/phase_degree_predictor.sv
module phase_degree_predictor
  import phd_pkg::*;
#(
  parameter int SIG_W   = 128,
  parameter int ENTRIES = 16,
  parameter int MET_W   = 16,
  parameter int TS_W    = 16,
  parameter int MAX_LAT = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_valid,
  output logic             sig_ready,
  input  logic [SIG_W-1:0] sig,
  input  logic [MET_W-1:0] metric_in,
  output logic             degree_valid,
  output logic [1:0]       degree,
  output logic             sig_clear
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int CNT_W  = $clog2(SIG_W + 1);
  localparam int PROD_W = 2 * CNT_W;
  localparam int LAT_W  = $clog2(MAX_LAT + 2);

  // table storage
  logic [SIG_W-1:0] key_q   [ENTRIES];
  logic [MET_W-1:0] met_q   [ENTRIES][3];
  deg_e             best_q  [ENTRIES];
  logic [1:0]       tried_q [ENTRIES];
  logic [TS_W-1:0]  ts_q    [ENTRIES];
  logic [ENTRIES-1:0] valid_q, tuned_q;

  // control state
  fsm_e             state_q;
  logic [SIG_W-1:0] sig_l;
  logic [MET_W-1:0] met_l;
  deg_e             cur_deg_q, degree_q;
  logic [IDX_W-1:0] prev_q, scan_q, near_idx_q, vic_idx_q;
  logic             prev_vld_q, near_vld_q, dv_q;
  logic [CNT_W-1:0] near_x_q, near_o_q;
  logic [1:0]       vic_rank_q;
  logic [TS_W-1:0]  vic_ts_q, tick_q;

  // distance of the scanned entry
  logic [CNT_W-1:0] dist_x, dist_o, cand_x, cand_o;
  phd_distance #(.SIG_W(SIG_W), .CNT_W(CNT_W)) u_dist (
    .sig_a(key_q[scan_q]), .sig_b(sig_l),
    .diff_cnt(dist_x), .union_cnt(dist_o)
  );

  always_comb begin
    if (dist_o == '0) begin
      cand_x = '0;
      cand_o = CNT_W'(1);
    end else begin
      cand_x = dist_x;
      cand_o = dist_o;
    end
  end

  // cross-multiplied ratio compare, strict so the lowest index wins ties
  logic take_near;
  assign take_near = valid_q[scan_q] &&
    (!near_vld_q || (PROD_W'(cand_x) * PROD_W'(near_o_q)) <
                    (PROD_W'(near_x_q) * PROD_W'(cand_o)));

  // replacement class: empty 0, tuning 1, tuned 2; older stamp loses first
  logic [1:0]      cand_rank;
  logic [TS_W-1:0] cand_ts;
  logic            vic_better;
  assign cand_rank  = !valid_q[scan_q] ? 2'd0 : (tuned_q[scan_q] ? 2'd2 : 2'd1);
  assign cand_ts    = valid_q[scan_q] ? ts_q[scan_q] : '0;
  assign vic_better = {cand_rank, cand_ts} < {vic_rank_q, vic_ts_q};

  // metric set of the previous entry with the new value merged in
  logic [MET_W-1:0] upd_m [3];
  deg_e             upd_best;
  always_comb begin
    for (int s = 0; s < 3; s++)
      upd_m[s] = (int'(cur_deg_q) == s) ? met_l : met_q[prev_q][s];
  end

  phd_best_sel #(.MET_W(MET_W)) u_best (
    .m_u1(upd_m[0]), .m_u2(upd_m[1]), .m_u4(upd_m[2]), .best(upd_best)
  );

  // decision for the coming interval
  logic             hit;
  logic [IDX_W-1:0] dec_idx;
  deg_e             dec_deg;
  assign hit = near_vld_q && ({near_x_q, 1'b0} <= {1'b0, near_o_q});
  always_comb begin
    if (hit) begin
      dec_idx = near_idx_q;
      dec_deg = tuned_q[near_idx_q] ? best_q[near_idx_q] : deg_e'(tried_q[near_idx_q]);
    end else begin
      dec_idx = vic_idx_q;
      dec_deg = DEG_U1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      sig_l      <= '0;
      met_l      <= '0;
      cur_deg_q  <= DEG_U1;
      degree_q   <= DEG_U1;
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
      scan_q     <= '0;
      near_idx_q <= '0;
      near_vld_q <= 1'b0;
      near_x_q   <= '0;
      near_o_q   <= '0;
      vic_idx_q  <= '0;
      vic_rank_q <= '0;
      vic_ts_q   <= '0;
      tick_q     <= '0;
      dv_q       <= 1'b0;
      valid_q    <= '0;
      tuned_q    <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        key_q[e]   <= '0;
        best_q[e]  <= DEG_U1;
        tried_q[e] <= '0;
        ts_q[e]    <= '0;
        for (int s = 0; s < 3; s++) met_q[e][s] <= '0;
      end
    end else begin
      dv_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (sig_valid) begin
            sig_l   <= sig;
            met_l   <= metric_in;
            state_q <= ST_UPDATE;
          end
        end
        ST_UPDATE: begin
          if (prev_vld_q) begin
            met_q[prev_q][cur_deg_q] <= met_l;
            if (tuned_q[prev_q]) begin
              best_q[prev_q] <= upd_best;
            end else begin
              tried_q[prev_q] <= tried_q[prev_q] + 2'd1;
              if (cur_deg_q == DEG_U4) begin
                tuned_q[prev_q] <= 1'b1;
                best_q[prev_q]  <= upd_best;
              end
            end
          end
          scan_q     <= '0;
          near_vld_q <= 1'b0;
          state_q    <= ST_SEARCH;
        end
        ST_SEARCH: begin
          if (take_near) begin
            near_vld_q <= 1'b1;
            near_idx_q <= scan_q;
            near_x_q   <= cand_x;
            near_o_q   <= cand_o;
          end
          if (scan_q == '0 || vic_better) begin
            vic_idx_q  <= scan_q;
            vic_rank_q <= cand_rank;
            vic_ts_q   <= cand_ts;
          end
          if (scan_q == IDX_W'(ENTRIES - 1)) state_q <= ST_DECIDE;
          else                              scan_q  <= scan_q + 1'b1;
        end
        ST_DECIDE: begin
          if (!hit) begin
            key_q[dec_idx]   <= sig_l;
            valid_q[dec_idx] <= 1'b1;
            tuned_q[dec_idx] <= 1'b0;
            tried_q[dec_idx] <= '0;
            best_q[dec_idx]  <= DEG_U1;
            for (int s = 0; s < 3; s++) met_q[dec_idx][s] <= '0;
          end
          ts_q[dec_idx] <= tick_q;
          tick_q        <= tick_q + 1'b1;
          prev_q        <= dec_idx;
          prev_vld_q    <= 1'b1;
          cur_deg_q     <= dec_deg;
          degree_q      <= dec_deg;
          dv_q          <= 1'b1;
          state_q       <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sig_ready    = (state_q == ST_IDLE);
  assign degree_valid = dv_q;
  assign sig_clear    = dv_q;
  assign degree       = degree_q;

  // ---------------- assertions ----------------
  logic [LAT_W-1:0] busy_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_cnt_q <= '0;
    else if (sig_ready) busy_cnt_q <= '0;
    else                busy_cnt_q <= busy_cnt_q + 1'b1;
  end

  a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_valid && sig_ready) |=> !sig_ready);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    degree_valid |=> !degree_valid);

  a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    degree_valid |-> degree != 2'b11);

  a_r2_latency_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt_q <= LAT_W'(MAX_LAT));

  a_r6_tuned_after_u4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_UPDATE && prev_vld_q && !tuned_q[prev_q] && cur_deg_q == DEG_U4)
    |=> tuned_q[prev_q]);

  a_r4_miss_gives_u1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DECIDE && !near_vld_q) |=> (degree_valid && degree == 2'b00));

endmodule

// File: tb/phase_degree_predictor_tb.sv
module phase_degree_predictor_tb;
  localparam int SIG_W = 128;
  localparam int MET_W = 16;
  localparam logic [1:0] U1 = 2'b00, U2 = 2'b01, U4 = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sig_valid = 1'b0;
  logic sig_ready;
  logic [SIG_W-1:0] sig = '0;
  logic [MET_W-1:0] metric_in = '0;
  logic degree_valid, sig_clear;
  logic [1:0] degree;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  always #2.5 clk = ~clk;

  phase_degree_predictor u_dut (
    .clk(clk), .rst_n(rst_n), .sig_valid(sig_valid), .sig_ready(sig_ready),
    .sig(sig), .metric_in(metric_in), .degree_valid(degree_valid),
    .degree(degree), .sig_clear(sig_clear)
  );

  // fields: byte slot[3:0], byte mask[7:0], metric[15:0], expected degree[1:0]
  localparam logic [29:0] VEC [14] = '{
    {4'd0, 8'hFF, 16'd0,   U1},  // R4 empty table miss
    {4'd0, 8'hFF, 16'd50,  U2},  // R5 second try
    {4'd0, 8'hFF, 16'd30,  U4},  // R5 third try
    {4'd0, 8'hFF, 16'd40,  U2},  // R6 tuned, best U2
    {4'd1, 8'hFF, 16'd60,  U1},  // R4 new phase
    {4'd0, 8'hFF, 16'd10,  U4},  // R7 recomputed best U4
    {4'd0, 8'hFF, 16'd99,  U1},  // R7 recomputed best U1
    {4'd2, 8'hFF, 16'd80,  U1},  // R4 new phase
    {4'd2, 8'hFF, 16'd9,   U2},  // R5
    {4'd2, 8'hFF, 16'd7,   U4},  // R5
    {4'd2, 8'hFF, 16'd7,   U2},  // R6 tie U2 vs U4 gives U2
    {4'd2, 8'hFE, 16'd5,   U2},  // R3 near match hits
    {4'd0, 8'h0F, 16'd3,   U2},  // R3 distance exactly one half hits
    {4'd0, 8'h07, 16'd5,   U1}   // R3 distance above one half misses
  };

  function automatic string vtag(int i);
    case (i)
      0, 4, 7:    return "R4";
      1, 2, 8, 9: return "R5";
      3, 10:      return "R6";
      5, 6:       return "R7";
      default:    return "R3";
    endcase
  endfunction

  function automatic logic [SIG_W-1:0] mk(input logic [3:0] slot, input logic [7:0] mask);
    return SIG_W'(mask) << (8 * int'(slot));
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run_iv(input logic [3:0] slot, input logic [7:0] mask,
                        input logic [15:0] met, input logic [1:0] exp,
                        input string tag, input bit garbage);
    int lat;
    bit got, ready_bad, clr_ok;
    logic [1:0] d;
    @(negedge clk);
    sig = mk(slot, mask);
    metric_in = met;
    sig_valid = 1'b1;
    @(posedge clk);
    #1 sig_valid = 1'b0;
    lat = 0; got = 0; ready_bad = 0; clr_ok = 0; d = 2'b11;
    while (!got && lat < 60) begin
      @(negedge clk);
      lat++;
      if (degree_valid) begin
        got = 1; d = degree; clr_ok = sig_clear;
      end else if (sig_ready) ready_bad = 1;
      if (garbage && lat < 8) begin
        sig = mk(4'd0, 8'hFF);
        sig_valid = 1'b1;
      end else sig_valid = 1'b0;
    end
    sig_valid = 1'b0;
    check(got && d == exp, tag, "degree", int'(d), int'(exp));
    check(clr_ok, "R2", "sig_clear with degree_valid", int'(clr_ok), 1);
    check(got && lat <= 50, "R2", "latency", lat, 50);
    check(!ready_bad, "R1", "sig_ready low while busy", int'(ready_bad), 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(sig_ready == 1'b1, "R9", "sig_ready in reset", int'(sig_ready), 1);
    check(degree_valid == 1'b0 && sig_clear == 1'b0, "R9", "outputs idle in reset",
          int'(degree_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(degree == U1, "R9", "degree after reset", int'(degree), int'(U1));

    for (int i = 0; i < 14; i++)
      run_iv(VEC[i][29:26], VEC[i][25:18], VEC[i][17:2], VEC[i][1:0], vtag(i), 1'b0);

    // fill the remaining twelve entries: all misses
    for (int k = 3; k < 15; k++)
      run_iv(4'(k), 8'hFF, 16'd100, U1, "R4", 1'b0);

    // R8: full table, tuning LRU (slot 1 phase) evicted first
    run_iv(4'd15, 8'hFF, 16'd100, U1, "R8", 1'b0);
    run_iv(4'd1,  8'hFF, 16'd100, U1, "R8", 1'b0);  // would be U2 if kept
    run_iv(4'd0,  8'h07, 16'd100, U1, "R8", 1'b0);
    run_iv(4'd0,  8'hFF, 16'd100, U2, "R8", 1'b0);  // tuned entry survived
    // R7: overwrite tuned slot U2 with a large metric, best moves to U1
    run_iv(4'd0,  8'hFF, 16'd500, U1, "R7", 1'b0);

    // R1: offers during busy are ignored
    run_iv(4'd2, 8'hFF, 16'd80, U2, "R1", 1'b1);
    begin
      int extra = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (degree_valid) extra++;
      end
      check(extra == 0, "R1", "pulses from ignored offers", extra, 0);
    end

    // R9: reset empties the table
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(sig_ready == 1'b1 && degree_valid == 1'b0, "R9", "idle during reset",
          int'(sig_ready), 1);
    rst_n = 1'b1;
    run_iv(4'd0, 8'hFF, 16'd1, U1, "R9", 1'b0);
    run_iv(4'd0, 8'hFF, 16'd1, U2, "R9", 1'b0);
    run_iv(4'd0, 8'hFF, 16'd1, U4, "R9", 1'b0);

    finish_run();
  end
endmodule